// File: doc/BRIEF.md
# Boot Page Jump Injector

This block makes an 8-bit CPU begin execution at any 256-byte page of the low 64 KB. After it is armed, it answers the CPU's first three read cycles itself with a three-byte absolute jump. The bytes are the opcode 0xC3, a zero low-address byte, and a configured page byte. While it answers, it holds the normal bus data-in buffer disabled. After the third read it gives the data path back to the bus, so the CPU continues from the jump target.

Power-on clear always arms the block. Two other events can arm it:
- A bus reset, but only when the rearm-on-reset option is set.
- A start pulse from the processor swap logic, issued when the CPU comes back online with reset-on-swap selected.

A global enable switches the function off. With the enable low, the CPU fetches its reset vector at 0x0000 from the bus as usual. The read strobe is sampled on the system clock, and the position in the sequence advances on each falling edge of the strobe.

Top module: `boot_jump_injector`

## Requirements
- R1: While power-on clear is high, and on the cycle after it falls, busy equals the enable input. The override is low whenever the read strobe is low.
- R2: With the enable low, every read returns with the override low and the injected byte 0x00, and busy stays low. This holds after any arming event.
- R3: While armed, the first read strobe presents byte 0xC3 on the injected data output.
- R4: While armed, the second read strobe presents 0x00.
- R5: While armed, the third read strobe presents the page input. Page bit 7 becomes address bit A15 and page bit 0 becomes A8, so the byte is passed unchanged.
- R6: The override is high only while the read strobe is high and the block is armed. Whenever the override is low, the injected byte is 0x00.
- R7: The clock edge that sees the third read strobe fall disarms the block. Busy is low from then on, and a fourth read sees the override low.
- R8: A bus reset arms the block when the rearm option is high. When the rearm option is low, a bus reset leaves the block idle.
- R9: A swap start pulse arms the block, and the sequence restarts from its first byte.
- R10: The sequence advances only on a falling edge of the read strobe. A strobe held high for many cycles keeps presenting the same byte.
- R11: An arming event in the middle of a sequence restarts it at 0xC3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on clear, active high, synchronous; arms the block |
| bus_reset_i | input | 1 | Bus reset, active high |
| inj_enable_i | input | 1 | Global enable for injection |
| rearm_on_reset_i | input | 1 | When high, a bus reset also arms the block |
| page_i | input | 8 | Target page; bit 7 is A15, bit 0 is A8 |
| swap_start_i | input | 1 | One-cycle pulse from the swap logic that arms the block |
| rd_strobe_i | input | 1 | CPU read strobe, active high |
| inj_data_o | output | 8 | Injected data byte; 0x00 when not overriding |
| din_override_o | output | 1 | High to disable the bus data-in buffer |
| busy_o | output | 1 | High from arming until disarm |

## Verification
The bench holds the strobe high across several clocks to catch a design that advances on level instead of on edge, since such a design would skip the zero byte. It checks that a fourth read reaches the bus, because a counter that wraps would loop back and inject 0xC3 forever. It gives a bus reset with the rearm option low, where a careless design would re-arm. It sends a swap start in the middle of a sequence, where a design that failed to clear the index would resume at the page byte. With the enable low it expects no override at all, which catches a design that gates only the data and not the buffer control.

// File: rtl/boot_jump_pkg.sv
package boot_jump_pkg;
    localparam int JMP_LEN = 3;
    localparam int IDX_W   = $clog2(JMP_LEN);

    typedef struct packed {
        logic             armed;
        logic [IDX_W-1:0] idx;
    } seq_state_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
    input  logic clk,
    input  logic rst_i,
    input  logic strobe_i,
    output logic fall_o
);
    logic strobe_d, strobe_q;

    always_comb begin
        strobe_d = rst_i ? 1'b0 : strobe_i;
        fall_o   = strobe_q & ~strobe_i;
    end

    always_ff @(posedge clk) begin
        strobe_q <= strobe_d;
    end
endmodule

// File: rtl/jump_sequencer.sv
module jump_sequencer
    import boot_jump_pkg::*;
(
    input  logic             clk,
    input  logic             por_i,
    input  logic             arm_i,
    input  logic             enable_i,
    input  logic             fall_i,
    output logic             armed_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(JMP_LEN - 1);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_i || arm_i) begin
            st_d.armed = enable_i;
            st_d.idx   = '0;
        end else if (!enable_i) begin
            st_d.armed = 1'b0;
            st_d.idx   = '0;
        end else if (st_q.armed && fall_i) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.armed = 1'b0;
                st_d.idx   = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign armed_o = st_q.armed;
    assign idx_o   = st_q.idx;
endmodule

// File: rtl/jump_byte_mux.sv
module jump_byte_mux
    import boot_jump_pkg::*;
#(
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] OPCODE = 8'hC3
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              drive_i,
    input  logic [DATA_W-1:0] page_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] sel;

    always_comb begin
        case (idx_i)
            IDX_W'(0): sel = OPCODE;
            IDX_W'(1): sel = '0;
            default:   sel = page_i;
        endcase
        data_o = drive_i ? sel : '0;
    end
endmodule

// File: rtl/boot_jump_injector.sv
module boot_jump_injector
    import boot_jump_pkg::*;
#(
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] OPCODE = 8'hC3
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              bus_reset_i,
    input  logic              inj_enable_i,
    input  logic              rearm_on_reset_i,
    input  logic [DATA_W-1:0] page_i,
    input  logic              swap_start_i,
    input  logic              rd_strobe_i,
    output logic [DATA_W-1:0] inj_data_o,
    output logic              din_override_o,
    output logic              busy_o
);
    logic             rd_fall;
    logic             armed;
    logic [IDX_W-1:0] idx;
    logic             arm_evt;
    logic             drive;

    assign arm_evt = swap_start_i | (bus_reset_i & rearm_on_reset_i);

    strobe_edge u_edge (
        .clk      (clk),
        .rst_i    (por_i),
        .strobe_i (rd_strobe_i),
        .fall_o   (rd_fall)
    );

    jump_sequencer u_seq (
        .clk      (clk),
        .por_i    (por_i),
        .arm_i    (arm_evt),
        .enable_i (inj_enable_i),
        .fall_i   (rd_fall),
        .armed_o  (armed),
        .idx_o    (idx)
    );

    assign drive = armed & inj_enable_i & rd_strobe_i;

    jump_byte_mux #(.DATA_W(DATA_W), .OPCODE(OPCODE)) u_mux (
        .idx_i   (idx),
        .drive_i (drive),
        .page_i  (page_i),
        .data_o  (inj_data_o)
    );

    assign din_override_o = drive;
    assign busy_o         = armed;
endmodule

// File: rtl/boot_jump_checker.sv
module boot_jump_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              por_i,
    input logic              bus_reset_i,
    input logic              inj_enable_i,
    input logic              rearm_on_reset_i,
    input logic              swap_start_i,
    input logic              rd_strobe_i,
    input logic [DATA_W-1:0] inj_data_o,
    input logic              din_override_o,
    input logic              busy_o
);
    // R1: the cycle after power-on clear, busy follows the enable
    p_por_arms_r1: assert property (@(posedge clk)
        $fell(por_i) |-> (busy_o == $past(inj_enable_i)));

    // R2: disabled means no override
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (por_i)
        !inj_enable_i |-> !din_override_o);

    // R6: override needs the strobe and an armed block
    p_override_gate_r6: assert property (@(posedge clk) disable iff (por_i)
        din_override_o |-> (rd_strobe_i && busy_o));

    // R6: idle data is zero
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (por_i)
        !din_override_o |-> (inj_data_o == '0));

    // R8: bus reset with rearm arms
    p_bus_rearm_r8: assert property (@(posedge clk) disable iff (por_i)
        (bus_reset_i && rearm_on_reset_i && inj_enable_i) |=> busy_o);

    // R9: swap start arms
    p_swap_arm_r9: assert property (@(posedge clk) disable iff (por_i)
        (swap_start_i && inj_enable_i) |=> busy_o);
endmodule

bind boot_jump_injector boot_jump_checker #(.DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .por_i            (por_i),
    .bus_reset_i      (bus_reset_i),
    .inj_enable_i     (inj_enable_i),
    .rearm_on_reset_i (rearm_on_reset_i),
    .swap_start_i     (swap_start_i),
    .rd_strobe_i      (rd_strobe_i),
    .inj_data_o       (inj_data_o),
    .din_override_o   (din_override_o),
    .busy_o           (busy_o)
);

// File: tb/boot_jump_injector_bench.sv
`timescale 1ns/1ps
module boot_jump_injector_bench;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       bus_reset = 1'b0;
    logic       en = 1'b1;
    logic       rearm = 1'b0;
    logic [7:0] page = 8'hE0;
    logic       swap = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] data;
    logic       ovr;
    logic       busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    boot_jump_injector u_boot_jump_injector (
        .clk              (clk),
        .por_i            (por),
        .bus_reset_i      (bus_reset),
        .inj_enable_i     (en),
        .rearm_on_reset_i (rearm),
        .page_i           (page),
        .swap_start_i     (swap),
        .rd_strobe_i      (rd),
        .inj_data_o       (data),
        .din_override_o   (ovr),
        .busy_o           (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One read cycle: raise strobe for hold cycles, check byte, drop strobe.
    task automatic read_cycle(input string req, input int hold,
                              input logic exp_ovr, input logic [7:0] exp_data);
        @(negedge clk); rd = 1'b1;
        for (int i = 0; i < hold; i++) begin
            #1;
            chk({req, " override"}, int'(ovr), int'(exp_ovr));
            chk({req, " data"}, int'(data), int'(exp_data));
            @(negedge clk);
        end
        rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_por(input logic enable);
        @(negedge clk); en = enable; por = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1 busy during por", int'(busy), int'(enable));
        por = 1'b0;
        @(negedge clk);
        chk("R1 busy after por", int'(busy), int'(enable));
        chk("R1 override idle", int'(ovr), 0);
    endtask

    task automatic t_sequence(input logic [7:0] pg);
        do_por(1'b1);
        page = pg;
        read_cycle("R3 first byte", 1, 1'b1, 8'hC3);
        read_cycle("R4 second byte", 1, 1'b1, 8'h00);
        read_cycle("R5 page byte", 1, 1'b1, pg);
        chk("R7 busy cleared", int'(busy), 0);
        read_cycle("R7 fourth read to bus", 1, 1'b0, 8'h00);
    endtask

    task automatic t_disabled();
        do_por(1'b0);
        read_cycle("R2 disabled read", 1, 1'b0, 8'h00);
        @(negedge clk); swap = 1'b1; @(negedge clk); swap = 1'b0;
        chk("R2 swap while disabled", int'(busy), 0);
        read_cycle("R2 disabled after swap", 1, 1'b0, 8'h00);
        en = 1'b1;
    endtask

    task automatic t_hold();
        do_por(1'b1);
        page = 8'h12;
        read_cycle("R10 held first byte", 4, 1'b1, 8'hC3);
        read_cycle("R10 held second byte", 3, 1'b1, 8'h00);
        read_cycle("R10 third byte", 1, 1'b1, 8'h12);
    endtask

    task automatic t_bus_reset();
        // block is idle after previous sequence
        @(negedge clk); rearm = 1'b0; bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        @(negedge clk);
        chk("R8 reset ignored busy", int'(busy), 0);
        read_cycle("R8 reset ignored read", 1, 1'b0, 8'h00);
        @(negedge clk); rearm = 1'b1; bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        chk("R8 reset rearm busy", int'(busy), 1);
        read_cycle("R8 rearmed first byte", 1, 1'b1, 8'hC3);
        read_cycle("R8 rearmed second byte", 1, 1'b1, 8'h00);
        read_cycle("R8 rearmed third byte", 1, 1'b1, page);
        rearm = 1'b0;
    endtask

    task automatic t_swap_restart();
        page = 8'hA5;
        @(negedge clk); swap = 1'b1; @(negedge clk); swap = 1'b0;
        chk("R9 swap arms", int'(busy), 1);
        read_cycle("R9 swap first byte", 1, 1'b1, 8'hC3);
        read_cycle("R11 second byte before restart", 1, 1'b1, 8'h00);
        @(negedge clk); swap = 1'b1; @(negedge clk); swap = 1'b0;
        read_cycle("R11 restart at opcode", 1, 1'b1, 8'hC3);
        read_cycle("R11 restart second", 1, 1'b1, 8'h00);
        read_cycle("R11 restart page", 1, 1'b1, 8'hA5);
        chk("R7 disarm after restart", int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        t_sequence(8'hE0);
        t_sequence(8'h01);
        t_disabled();
        t_hold();
        t_bus_reset();
        t_swap_restart();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule